// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block acts as the target end of a two-wire serial bus and behaves like a byte-wide serial EEPROM. A fast system clock oversamples the bus clock and data lines. The block finds the bus start and stop events and compares the incoming device byte with a fixed family code and a 3-bit strap. It answers by pulling the data line low through an output enable, since the line is open-drain. The array is held in on-chip RAM. Its depth is set by a parameter: the default is 2K bytes, and 15 address bits give the full 32K.

A bus master stores data with single-byte or multi-byte writes. It fetches data from the current pointer, from an address it has just loaded, or as a stream of bytes that it acknowledges one at a time. The write to non-volatile storage is modelled as a busy window of programmable length. The window opens at the stop event that closes a write. While it runs, the block refuses its own device address, so a master can poll for completion. A write-protect input keeps the array unchanged.

Top module: `ee2w_slave`

## Requirements
- R1: A falling data line while the bus clock is high is a start event. It aborts any partial byte and restarts device-byte reception. A rising data line while the bus clock is high is a stop event. It returns the block to idle with the data line released.
- R2: The device byte is accepted when bits 7:4 equal 1010 and bits 3:1 equal `strap_i`. Bit 0 set to 1 selects read. An accepted byte is acknowledged by pulling SDA low during the ninth bus clock. On a mismatch the block does not acknowledge, and it ignores the bus until the next start event.
- R3: A write passes two address bytes, high byte first, and each is acknowledged. Only the low ADDR_W bits of the 16 received bits select the location. The upper bits are ignored.
- R4: Every data byte after the address bytes is acknowledged and stored at the pointer. A later read of that location returns it.
- R5: During a write, only the low PAGE_W pointer bits advance. The byte after the last location of a 64-byte page goes to the first location of the same page and overwrites it.
- R6: A stop event that ends a write which stored at least one byte starts a busy window of BUSY_CYC system clocks. During the window the device byte is not acknowledged. After the window it is acknowledged again.
- R7: With `wp_i` high, data bytes are still acknowledged. The array is left unchanged, and no busy window starts.
- R8: The pointer holds the last accessed location plus one. A read that starts with no address phase returns that location.
- R9: A random read is a write of the two address bytes, then a repeated start and a read device byte. It returns the byte at the loaded address.
- R10: When the master acknowledges a read byte, the next location follows. The pointer wraps from the last array location to location 0.
- R11: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next start event.
- R12: The block changes `sda_oe` only while the bus clock is low, and never during a bus-clock high phase.
- R13: After reset `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Strapped device-select bits |
| wp_i | input | 1 | Write protect. High blocks array updates |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The two-stage synchronizer and the edge register put every reaction of the block three to four system clocks after the bus edge that causes it. This covers the acknowledge pull, each read bit and each release. The bench holds every bus-clock phase for eight system clocks and samples the data line in the middle of the high phase, when the due value has settled. The busy window counts BUSY_CYC clocks from the detected stop event. The bench polls right after the stop, well inside a 400-clock window, and polls again only after waiting longer than the window. A monitor checks on every clock that `sda_oe` never changes while the bus clock stays high.

// File: rtl/ee2w_pkg.sv
`timescale 1ns/1ps
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } ee2w_state_t;

  localparam logic [3:0] FAMILY_CODE = 4'b1010;
endpackage

// File: rtl/ee2w_line_sync.sv
`timescale 1ns/1ps
module ee2w_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_now, sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_now;
      sda_q  <= sda_now;
    end
  end

  assign scl_now   = scl_sh[STAGES-1];
  assign sda_now   = sda_sh[STAGES-1];
  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_now;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_now;
endmodule

// File: rtl/ee2w_busy_timer.sv
`timescale 1ns/1ps
module ee2w_busy_timer #(
  parameter int CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (go)        cnt <= CW'(CYC);
    else if (cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(cnt) == CW'(1)));
endmodule

// File: rtl/ee2w_array.sv
`timescale 1ns/1ps
module ee2w_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ee2w_slave.sv
`timescale 1ns/1ps
module ee2w_slave
  import ee2w_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYC    = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe
);
  localparam logic [PAGE_W-1:0] PG_ONE   = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [3:0]        BIT_END  = 4'd8;

  logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  logic busy, busy_go;

  ee2w_state_t       st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txsh, hi_byte;
  logic [ADDR_W-1:0] ptr, wa_q;
  logic [7:0]        wd_q, rdata;
  logic              in_ack, mack, wrote, oe, we_q;

  logic              dev_hit;
  logic [15:0]       full_addr;
  logic [PAGE_W-1:0] pg_off;
  logic [ADDR_W-1:0] page_next, lin_next;

  ee2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det)
  );

  ee2w_busy_timer #(.CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .go(busy_go), .busy_o(busy)
  );

  ee2w_array #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(we_q), .waddr(wa_q), .wdata(wd_q),
    .raddr(ptr), .rdata(rdata)
  );

  assign dev_hit   = (shreg[7:4] == FAMILY_CODE) && (shreg[3:1] == strap_i) && !busy;
  assign full_addr = {hi_byte, shreg};
  assign pg_off    = ptr[PAGE_W-1:0] + PG_ONE;
  assign page_next = {ptr[ADDR_W-1:PAGE_W], pg_off};
  assign lin_next  = ptr + ADDR_ONE;
  assign sda_oe    = oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      hi_byte <= '0;
      ptr     <= '0;
      wa_q    <= '0;
      wd_q    <= '0;
      in_ack  <= 1'b0;
      mack    <= 1'b0;
      wrote   <= 1'b0;
      oe      <= 1'b0;
      we_q    <= 1'b0;
      busy_go <= 1'b0;
    end else begin
      we_q    <= 1'b0;
      busy_go <= 1'b0;
      if (start_det) begin
        st     <= ST_DEV;
        bitcnt <= '0;
        in_ack <= 1'b0;
        oe     <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        in_ack <= 1'b0;
        oe     <= 1'b0;
        if (wrote) busy_go <= 1'b1;
        wrote  <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise && bitcnt != BIT_END) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == BIT_END && !in_ack) begin
              in_ack <= 1'b1;
              case (st)
                ST_DEV: begin
                  if (dev_hit) oe <= 1'b1;
                  else         st <= ST_SKIP;
                end
                ST_AHI: begin
                  hi_byte <= shreg;
                  oe      <= 1'b1;
                end
                ST_ALO: begin
                  ptr <= full_addr[ADDR_W-1:0];
                  oe  <= 1'b1;
                end
                default: begin
                  oe  <= 1'b1;
                  ptr <= page_next;
                  if (!wp_i) begin
                    we_q  <= 1'b1;
                    wa_q  <= ptr;
                    wd_q  <= shreg;
                    wrote <= 1'b1;
                  end
                end
              endcase
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              bitcnt <= '0;
              oe     <= 1'b0;
              case (st)
                ST_DEV: begin
                  if (shreg[0]) begin
                    st   <= ST_RDAT;
                    txsh <= rdata;
                    oe   <= ~rdata[7];
                    ptr  <= lin_next;
                  end else begin
                    st <= ST_AHI;
                  end
                end
                ST_AHI:  st <= ST_ALO;
                ST_ALO:  st <= ST_WDAT;
                default: st <= ST_WDAT;
              endcase
            end
          end
          ST_RDAT: begin
            if (scl_rise && bitcnt != BIT_END) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_rise && in_ack) begin
              mack <= ~sda_lvl;
            end else if (scl_fall && bitcnt != BIT_END) begin
              txsh <= {txsh[6:0], 1'b0};
              oe   <= ~txsh[6];
            end else if (scl_fall && !in_ack) begin
              in_ack <= 1'b1;
              oe     <= 1'b0;
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              if (mack) begin
                txsh   <= rdata;
                oe     <= ~rdata[7];
                ptr    <= lin_next;
                bitcnt <= '0;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: oe <= 1'b0;
        endcase
      end
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_SKIP) |-> !sda_oe);

  // R6
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !we_q);

  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |-> !$past(wp_i));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WDAT && $past(st) == ST_WDAT) |-> $stable(ptr[ADDR_W-1:PAGE_W]));

  // R2
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= BIT_END);
endmodule

// File: tb/ee2w_slave_bench.sv
`timescale 1ns/1ps
module ee2w_slave_bench;
  localparam int AW = 11;
  localparam int PW = 6;
  localparam int BC = 400;
  localparam int Q  = 8;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_low = 1'b0, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe, sda_line;
  assign sda_line = !(m_low || sda_oe);

  ee2w_slave #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_CYC(BC)) u_ee2w_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_oe(sda_oe)
  );

  always #5 clk = ~clk;

  typedef struct { int req; logic [7:0] val; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] obs_q[$];
  int n_chk = 0, n_bad = 0, viol = 0;
  bit done = 0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(int req, logic [7:0] act, logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (obs_q.size() > 0) begin
      logic [7:0] a;
      a = obs_q.pop_front();
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R0: actual %h expected none", a);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, a, e.val);
      end
    end
  end

  // R12: no sda_oe change during an SCL high phase
  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    #1;
    if (!rst && scl && scl_p && (sda_oe !== oe_p)) viol++;
    scl_p = scl;
    oe_p  = sda_oe;
  end

  task automatic bus_start;
    m_low = 0; tick(Q); scl = 1; tick(Q); m_low = 1; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic bus_stop;
    m_low = 1; tick(Q); scl = 1; tick(Q); m_low = 0; tick(2*Q);
  endtask

  task automatic put_bit(logic b);
    m_low = !b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask

  // ack encoding: 1 = acknowledged (SDA low in ninth clock)
  task automatic send_byte(logic [7:0] v, logic exp_ack, int req);
    exp_q.push_back('{req, {7'd0, exp_ack}});
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    m_low = 0; tick(Q); scl = 1; tick(Q);
    obs_q.push_back({7'd0, !sda_line});
    tick(Q); scl = 0; tick(Q);
  endtask

  task automatic get_byte(logic [7:0] expv, logic give_ack, int req);
    logic [7:0] r;
    exp_q.push_back('{req, expv});
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1; tick(Q); r[i] = sda_line; tick(Q); scl = 0; tick(Q);
    end
    obs_q.push_back(r);
    m_low = give_ack; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); m_low = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R0: watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(4); rst = 0; tick(2);
    chk(13, {7'd0, sda_oe}, 8'd0);                   // R13

    // R2: strap mismatch, then the bus is ignored
    bus_start;
    send_byte(8'hA0, 1'b0, 2);
    send_byte(8'h12, 1'b0, 2);
    bus_stop;

    // R3 R4: byte write; upper address bit ignored (0x81 -> 0x1xx)
    bus_start;
    send_byte(DEV_W, 1'b1, 2);
    send_byte(8'h81, 1'b1, 3);
    send_byte(8'h23, 1'b1, 3);
    send_byte(8'h5C, 1'b1, 4);
    bus_stop;
    // R6: polling while busy is refused
    bus_start;
    send_byte(DEV_W, 1'b0, 6);
    bus_stop;
    tick(BC + 50);

    // R1 abort mid byte, R6 ack resumes, R9 random read
    bus_start;
    for (int i = 7; i >= 4; i--) put_bit(DEV_W[i]);
    bus_start;
    send_byte(DEV_W, 1'b1, 6);
    send_byte(8'h01, 1'b1, 3);
    send_byte(8'h23, 1'b1, 3);
    bus_start;
    send_byte(DEV_R, 1'b1, 9);
    get_byte(8'h5C, 1'b0, 9);
    bus_stop;
    tick(2);
    chk(1, {7'd0, sda_oe}, 8'd0);                    // R1

    // R5: 66 bytes into the page at 0x240
    bus_start;
    send_byte(DEV_W, 1'b1, 5);
    send_byte(8'h02, 1'b1, 5);
    send_byte(8'h40, 1'b1, 5);
    for (int i = 0; i < 66; i++) send_byte(pat(i), 1'b1, 5);
    bus_stop;
    tick(BC + 50);

    // R8: current read returns 0x242; R11 nack then released line
    bus_start;
    send_byte(DEV_R, 1'b1, 8);
    get_byte(pat(2), 1'b0, 8);
    get_byte(8'hFF, 1'b0, 11);
    bus_stop;

    // R10 sequential read of the page, R5 wrap contents
    bus_start;
    send_byte(DEV_W, 1'b1, 9);
    send_byte(8'h02, 1'b1, 9);
    send_byte(8'h40, 1'b1, 9);
    bus_start;
    send_byte(DEV_R, 1'b1, 9);
    for (int j = 0; j < 64; j++)
      get_byte((j < 2) ? pat(64 + j) : pat(j), (j != 63), 5);
    bus_stop;

    // R10 array wrap: 0x7FF then 0x000
    bus_start;
    send_byte(DEV_W, 1'b1, 4);
    send_byte(8'h07, 1'b1, 4);
    send_byte(8'hFF, 1'b1, 4);
    send_byte(8'hE1, 1'b1, 4);
    bus_stop;
    tick(BC + 50);
    bus_start;
    send_byte(DEV_W, 1'b1, 4);
    send_byte(8'h00, 1'b1, 4);
    send_byte(8'h00, 1'b1, 4);
    send_byte(8'h1E, 1'b1, 4);
    bus_stop;
    tick(BC + 50);
    bus_start;
    send_byte(DEV_W, 1'b1, 10);
    send_byte(8'h07, 1'b1, 10);
    send_byte(8'hFF, 1'b1, 10);
    bus_start;
    send_byte(DEV_R, 1'b1, 10);
    get_byte(8'hE1, 1'b1, 10);
    get_byte(8'h1E, 1'b0, 10);
    bus_stop;

    // R7: protected write acked, no busy, array unchanged
    wp = 1;
    bus_start;
    send_byte(DEV_W, 1'b1, 7);
    send_byte(8'h00, 1'b1, 7);
    send_byte(8'h00, 1'b1, 7);
    send_byte(8'h99, 1'b1, 7);
    bus_stop;
    bus_start;
    send_byte(DEV_W, 1'b1, 7);
    send_byte(8'h00, 1'b1, 7);
    send_byte(8'h00, 1'b1, 7);
    bus_start;
    send_byte(DEV_R, 1'b1, 7);
    get_byte(8'h1E, 1'b0, 7);
    bus_stop;
    wp = 0;

    tick(4);
    chk(12, viol[7:0], 8'd0);                        // R12
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++; n_bad++;
      $display("FAIL R%0d: actual none expected %h", e.req, e.val);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule